// File: doc/BRIEF.md
# Codec Status Slot Decoder and Output Slot Scheduler

This block sits on the receive side of an AC-link controller. Once per input frame it is handed the two status slot words (slot 1 and slot 2), already converted to parallel 20-bit form, together with the slot 0 tag bits that mark those two slots as valid. From slot 1 it reads the codec's active-low requests for output slots 3 to 9. It turns them into a vector of active-high slot enables. The output framer uses that vector on the next outgoing frame to decide which PCM and modem slots it fills with data and which it tags invalid.

The enables are staged when the status slots arrive and move to the output only on a `frame_end` strobe. They then stay frozen for the whole following output frame. A fixed-rate mode forces every implemented slot on. When both status slots are tagged valid, the block also captures the echoed 7-bit register index and the 16-bit register read data. It pulses a completion signal and clears a pending-read flag that the command side raises. The codec must request paired channels together. A request pair that disagrees latches an error flag.

Top module: `acl_slotreq_sched`

## Requirements
- R1: After a synchronous active-low reset, `slot_en`, `pair_err`, `rd_pending` and `rd_done` are all 0.
- R2: Bit k of `slot_en` (k = 0..6) enables output slot k+3 and is the inverse of `in_slot1` bit 11-k as staged at the last `in_valid`. A 0 request bit means the slot is wanted.
- R3: `slot_en` changes only on the clock edge that samples `frame_end` high. A new `in_valid` between frame ends does not alter it.
- R4: Requests are honored whether `in_tag_s1` is 1 or 0.
- R5: If the requests for slots 3/4, 7/8 or 6/9 (slot 1 bits 11/10, 7/6, 8/5) disagree at an `in_valid`, `pair_err` goes high on the next cycle and stays high until reset. Agreeing pairs leave it low.
- R6: When `fixed_rate` is 1 at `frame_end`, `slot_en` becomes 0x07F whatever the request bits are.
- R7: Slot 1 bits 19, 4, 3, 2, 1 and 0 have no effect. `slot_en` bits 9..7 (slots 10 to 12) are always 0.
- R8: An `in_valid` with both `in_tag_s1` and `in_tag_s2` at 1 gives a one-cycle `rd_done` on the next cycle. In that cycle `rd_index` = `in_slot1`[18:12] and `rd_data` = `in_slot2`[19:4]. Slot 2 bits 3..0 are ignored.
- R9: An `in_valid` with either tag at 0 gives no `rd_done`, and `rd_index` and `rd_data` keep their values.
- R10: `rd_issue` sets `rd_pending` on the next cycle. `rd_pending` reads 0 in the cycle in which `rd_done` is high, unless `rd_issue` was high on the same edge.
- R11: A `frame_end` that comes before any `in_valid` since reset leaves `slot_en` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | One-cycle strobe: status slots of this frame are presented |
| in_tag_s1 | input | 1 | Slot 0 tag for slot 1 |
| in_tag_s2 | input | 1 | Slot 0 tag for slot 2 |
| in_slot1 | input | 20 | Status address slot word |
| in_slot2 | input | 20 | Status data slot word |
| frame_end | input | 1 | Strobe moving staged requests to the output |
| fixed_rate | input | 1 | 1 forces all implemented slots on |
| rd_issue | input | 1 | Command side has issued a register read |
| slot_en | output | 10 | Next-frame enables, bit 0 = slot 3 ... bit 9 = slot 12 |
| pair_err | output | 1 | Sticky paired-request mismatch |
| rd_pending | output | 1 | A register read awaits its answer |
| rd_done | output | 1 | One-cycle read completion pulse |
| rd_index | output | 7 | Captured echoed register index |
| rd_data | output | 16 | Captured register read data |

## Verification
The bench builds the block with its default parameters: 20-bit slots, seven implemented requests and a ten-bit enable vector. With these values the unimplemented slots 10 to 12, which sit at the top of the vector, can be observed, and so can the reserved bits next to the request field. The request patterns cover all slots wanted, none wanted, a single valid pair, a five-slot group, and a pair split between wanted and not wanted. The bench presents status slots both with and without `frame_end`, so that staging can be told apart from application. It also presents status slots under each tag combination, so that index capture can be told apart from request use.

// File: rtl/acl_slotreq_pkg.sv
// Package: shared field positions and request pairing for the slot scheduler.
// Assumes slot 1 carries requests for slot 3 at its highest request bit.
package acl_slotreq_pkg;
    // Bit of slot 1 holding the request for output slot 3.
    localparam int REQ_MSB  = 11;
    // Lowest bit of the echoed register index in slot 1.
    localparam int IDX_LSB  = 12;
    // Number of request pairs that must agree.
    localparam int N_PAIRS  = 3;
    // Pair members as enable-vector indices (0 = slot 3): 3/4, 7/8, 6/9.
    localparam int PAIR_A [N_PAIRS] = '{0, 4, 3};
    localparam int PAIR_B [N_PAIRS] = '{1, 5, 6};
endpackage

// File: rtl/acl_req_decode.sv
// Module: acl_req_decode
// Turns the active-low request field of slot 1 into an active-high enable
// vector and flags any request pair whose members disagree.
// Assumes: purely combinational, requests start at REQ_MSB and descend.
module acl_req_decode
    import acl_slotreq_pkg::*;
#(
    parameter int SLOT_W = 20,
    parameter int N_REQ  = 7,
    parameter int N_OUT  = 10
) (
    input  logic [SLOT_W-1:0] slot1,
    output logic [N_OUT-1:0]  req_vec,
    output logic              pair_bad
);
    logic [N_PAIRS-1:0] mism;

    // Implemented slots invert the request bit; the rest stay off.
    for (genvar k = 0; k < N_OUT; k++) begin : g_req
        if (k < N_REQ) begin : g_impl
            assign req_vec[k] = ~slot1[REQ_MSB-k];
        end else begin : g_none
            assign req_vec[k] = 1'b0;
        end
    end

    // One mismatch detector per channel pair.
    for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
        assign mism[p] = req_vec[PAIR_A[p]] ^ req_vec[PAIR_B[p]];
    end

    assign pair_bad = |mism;
endmodule

// File: rtl/acl_frame_stage.sv
// Module: acl_frame_stage
// Stages decoded requests when status slots arrive and applies them to the
// output enables on frame_end; output holds for the whole next frame.
// Assumes: load and frame_end are single-cycle strobes; before the first
// load after reset, frame_end leaves the enables cleared.
module acl_frame_stage #(
    parameter int N_REQ = 7,
    parameter int N_OUT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [N_OUT-1:0] req_vec,
    input  logic             frame_end,
    input  logic             fixed_rate,
    output logic [N_OUT-1:0] slot_en
);
    localparam int N_OFF = N_OUT - N_REQ;
    localparam logic [N_OUT-1:0] ALL_ON = {{N_OFF{1'b0}}, {N_REQ{1'b1}}};

    logic [N_OUT-1:0] staged;
    logic             have_frame;

    // Capture requests of the current input frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged     <= '0;
            have_frame <= 1'b0;
        end else if (load) begin
            staged     <= req_vec;
            have_frame <= 1'b1;
        end
    end

    // Apply staged requests (or the fixed-rate set) at the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_en <= '0;
        end else if (frame_end && have_frame) begin
            slot_en <= fixed_rate ? ALL_ON : staged;
        end
    end
endmodule

// File: rtl/acl_status_capture.sv
// Module: acl_status_capture
// Captures the echoed register index and read data when both status slots
// are tagged valid, pulses rd_done and manages the pending-read flag.
// Assumes: read data is top-aligned in slot 2; a new issue beats a clear.
module acl_status_capture
    import acl_slotreq_pkg::*;
#(
    parameter int SLOT_W = 20,
    parameter int IDX_W  = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              tag1,
    input  logic              tag2,
    input  logic [SLOT_W-1:0] slot1,
    input  logic [SLOT_W-1:0] slot2,
    input  logic              rd_issue,
    output logic              rd_done,
    output logic [IDX_W-1:0]  rd_index,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_pending
);
    localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

    logic hit;
    assign hit = load && tag1 && tag2;

    // Register index and data capture with completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_done  <= 1'b0;
            rd_index <= '0;
            rd_data  <= '0;
        end else begin
            rd_done <= hit;
            if (hit) begin
                rd_index <= slot1[IDX_MSB:IDX_LSB];
                rd_data  <= slot2[SLOT_W-1 -: DATA_W];
            end
        end
    end

    // Pending-read flag: set by the command side, cleared by completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pending <= 1'b0;
        end else if (rd_issue) begin
            rd_pending <= 1'b1;
        end else if (hit) begin
            rd_pending <= 1'b0;
        end
    end
endmodule

// File: rtl/acl_slotreq_sched.sv
// Module: acl_slotreq_sched (top)
// Decodes the two status slots of each input frame: schedules next-frame
// output slot enables, checks request pairing, and completes register reads.
// Assumes: slot words and tags are stable in the in_valid cycle; frame_end
// is not asserted in the same cycle as in_valid.
module acl_slotreq_sched #(
    parameter int SLOT_W = 20,
    parameter int IDX_W  = 7,
    parameter int DATA_W = 16,
    parameter int N_REQ  = 7,
    parameter int N_OUT  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_tag_s1,
    input  logic              in_tag_s2,
    input  logic [SLOT_W-1:0] in_slot1,
    input  logic [SLOT_W-1:0] in_slot2,
    input  logic              frame_end,
    input  logic              fixed_rate,
    input  logic              rd_issue,
    output logic [N_OUT-1:0]  slot_en,
    output logic              pair_err,
    output logic              rd_pending,
    output logic              rd_done,
    output logic [IDX_W-1:0]  rd_index,
    output logic [DATA_W-1:0] rd_data
);
    logic [N_OUT-1:0] req_vec;
    logic             pair_bad;

    acl_req_decode #(
        .SLOT_W(SLOT_W), .N_REQ(N_REQ), .N_OUT(N_OUT)
    ) u_decode (
        .slot1   (in_slot1),
        .req_vec (req_vec),
        .pair_bad(pair_bad)
    );

    acl_frame_stage #(
        .N_REQ(N_REQ), .N_OUT(N_OUT)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (in_valid),
        .req_vec   (req_vec),
        .frame_end (frame_end),
        .fixed_rate(fixed_rate),
        .slot_en   (slot_en)
    );

    acl_status_capture #(
        .SLOT_W(SLOT_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (in_valid),
        .tag1      (in_tag_s1),
        .tag2      (in_tag_s2),
        .slot1     (in_slot1),
        .slot2     (in_slot2),
        .rd_issue  (rd_issue),
        .rd_done   (rd_done),
        .rd_index  (rd_index),
        .rd_data   (rd_data),
        .rd_pending(rd_pending)
    );

    // Sticky protocol error on any disagreeing request pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_err <= 1'b0;
        end else if (in_valid && pair_bad) begin
            pair_err <= 1'b1;
        end
    end
endmodule

// File: rtl/acl_slotreq_sched_chk.sv
// Module: acl_slotreq_sched_chk
// Assertion checker bound to acl_slotreq_sched; observes ports only.
module acl_slotreq_sched_chk #(
    parameter int N_REQ = 7,
    parameter int N_OUT = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_tag_s1,
    input logic             in_tag_s2,
    input logic             frame_end,
    input logic             fixed_rate,
    input logic             rd_issue,
    input logic [N_OUT-1:0] slot_en,
    input logic             pair_err,
    input logic             rd_pending,
    input logic             rd_done
);
    localparam logic [N_OUT-1:0] ALL_ON = {{(N_OUT-N_REQ){1'b0}}, {N_REQ{1'b1}}};

    logic seen;

    // Tracks whether any status slots have arrived since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        seen <= 1'b0;
        else if (in_valid) seen <= 1'b1;
    end

    a_r3_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(slot_en));

    a_r6_fixed_all: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && fixed_rate && seen) |=> (slot_en == ALL_ON));

    a_r11_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> (slot_en == '0));

    a_r7_upper_off: assert property (@(posedge clk) disable iff (!rst_n)
        slot_en[N_OUT-1:N_REQ] == '0);

    a_r8_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> $past(in_valid && in_tag_s1 && in_tag_s2));

    a_r10_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !$past(rd_issue)) |-> !rd_pending);

    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        pair_err |=> pair_err);
endmodule

bind acl_slotreq_sched acl_slotreq_sched_chk #(
    .N_REQ(N_REQ), .N_OUT(N_OUT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_tag_s1 (in_tag_s1),
    .in_tag_s2 (in_tag_s2),
    .frame_end (frame_end),
    .fixed_rate(fixed_rate),
    .rd_issue  (rd_issue),
    .slot_en   (slot_en),
    .pair_err  (pair_err),
    .rd_pending(rd_pending),
    .rd_done   (rd_done)
);

// File: tb/acl_slotreq_sched_bench.sv
// Scoreboard bench: driver tasks queue expected enables and read results,
// a monitor at the falling edge pops and compares them.
module acl_slotreq_sched_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_tag_s1 = 1'b0, in_tag_s2 = 1'b0;
    logic [19:0] in_slot1 = '0, in_slot2 = '0;
    logic        frame_end = 1'b0, fixed_rate = 1'b0, rd_issue = 1'b0;
    logic [9:0]  slot_en;
    logic        pair_err, rd_pending, rd_done;
    logic [6:0]  rd_index;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;

    logic [9:0]  q_en[$];
    string       q_en_req[$];
    logic [22:0] q_rd[$];

    logic [6:0]  last_req_n = 7'h7F;
    bit          have_stat = 0;
    logic        fe_q = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acl_slotreq_sched u_acl_slotreq_sched (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_tag_s1(in_tag_s1), .in_tag_s2(in_tag_s2),
        .in_slot1(in_slot1), .in_slot2(in_slot2),
        .frame_end(frame_end), .fixed_rate(fixed_rate), .rd_issue(rd_issue),
        .slot_en(slot_en), .pair_err(pair_err), .rd_pending(rd_pending),
        .rd_done(rd_done), .rd_index(rd_index), .rd_data(rd_data)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Slot 1 word: reserved bit 19, index 18:12, requests 11:5, slots 10-12, reserved 1:0.
    function automatic logic [19:0] mk_s1(logic [6:0] idx, logic [6:0] req_n,
                                           logic [2:0] hi_n, logic rsv);
        return {rsv, idx, req_n, hi_n, {2{rsv}}};
    endfunction

    function automatic logic [9:0] dec_en(logic [6:0] req_n);
        logic [9:0] e = '0;
        for (int k = 0; k < 7; k++) e[k] = ~req_n[6-k];
        return e;
    endfunction

    // Present status slots for one frame; queue a read result when tags are valid.
    task automatic send_status(logic [19:0] s1, logic [19:0] s2, logic t1, logic t2);
        @(negedge clk);
        in_slot1 = s1; in_slot2 = s2; in_tag_s1 = t1; in_tag_s2 = t2; in_valid = 1'b1;
        last_req_n = s1[11:5];
        have_stat = 1;
        if (t1 && t2) q_rd.push_back({s1[18:12], s2[19:4]});
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // End a frame; queue the enables expected from the staged requests.
    task automatic end_frame(string req);
        @(negedge clk);
        q_en.push_back(!have_stat ? 10'h000 : (fixed_rate ? 10'h07F : dec_en(last_req_n)));
        q_en_req.push_back(req);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
    endtask

    always @(posedge clk) fe_q <= frame_end;

    // Monitor: compare design results against the scoreboard queues.
    always @(negedge clk) begin
        if (rst_n && fe_q) begin
            if (q_en.size() == 0) check("R3 unexpected update", 1, 0);
            else check(q_en_req.pop_front(), {22'b0, slot_en}, {22'b0, q_en.pop_front()});
        end
        if (rst_n && rd_done) begin
            if (q_rd.size() == 0) check("R9 unexpected rd_done", 1, 0);
            else begin
                check("R8 index/data", {9'b0, rd_index, rd_data}, {9'b0, q_rd.pop_front()});
                check("R10 pending cleared", {31'b0, rd_pending}, 0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 slot_en", {22'b0, slot_en}, 0);
        check("R1 pair_err", {31'b0, pair_err}, 0);
        check("R1 rd_pending", {31'b0, rd_pending}, 0);
        check("R1 rd_done", {31'b0, rd_done}, 0);
        rst_n = 1'b1;

        // R11: frame end before any status slots.
        end_frame("R11 no status yet");

        // R2/R8: all requested, valid read; R3: no change before frame_end.
        send_status(mk_s1(7'h55, 7'b0000000, 3'b111, 1'b0), {16'hBEEF, 4'hF}, 1'b1, 1'b1);
        check("R3 hold before frame_end", {22'b0, slot_en}, 0);
        end_frame("R2 all requested");

        // R4/R7: slot 1 tag clear, only slots 3/4, reserved bits and slots 10-12 set active.
        send_status(mk_s1(7'h2A, 7'b0011111, 3'b000, 1'b1), 20'h12345, 1'b0, 1'b1);
        check("R9 index held", {25'b0, rd_index}, 32'h55);
        check("R9 data held", {16'b0, rd_data}, 32'hBEEF);
        end_frame("R4 R7 untagged pair 3/4");

        // R3: new status without frame_end does not move enables.
        send_status(mk_s1(7'h11, 7'b1100000, 3'b111, 1'b0), {16'h0F0F, 4'h0}, 1'b1, 1'b1);
        check("R3 hold across status", {22'b0, slot_en}, 32'h003);
        check("R5 no mismatch", {31'b0, pair_err}, 0);
        end_frame("R2 slots 5-9");

        // R6: fixed rate overrides an all-idle request field.
        fixed_rate = 1'b1;
        send_status(mk_s1(7'h00, 7'b1111111, 3'b111, 1'b0), 20'h0, 1'b0, 1'b0);
        end_frame("R6 fixed rate");
        fixed_rate = 1'b0;
        end_frame("R2 no requests");

        // R10: issue a read, then complete it.
        @(negedge clk); rd_issue = 1'b1;
        @(negedge clk); rd_issue = 1'b0;
        check("R10 pending set", {31'b0, rd_pending}, 1);
        send_status(mk_s1(7'h7F, 7'b1111111, 3'b111, 1'b0), {16'h0001, 4'hA}, 1'b1, 1'b1);

        // R5: split pair 3/4 latches the error; it stays after clean frames.
        send_status(mk_s1(7'h00, 7'b0111111, 3'b111, 1'b0), 20'h0, 1'b0, 1'b0);
        check("R5 mismatch flagged", {31'b0, pair_err}, 1);
        end_frame("R5 split pair enables");
        send_status(mk_s1(7'h00, 7'b0011111, 3'b111, 1'b0), 20'h0, 1'b0, 1'b0);
        end_frame("R2 pair 3/4");
        check("R5 sticky", {31'b0, pair_err}, 1);

        repeat (2) @(negedge clk);
        check("R3 enable queue drained", q_en.size(), 0);
        check("R8 read queue drained", q_rd.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule